// File: doc/BRIEF.md
# Register-Banked Reorder Buffer

This block tracks in-flight instructions between issue and commit. Its 32 entries are divided into four banks of eight. The bank that receives an instruction is fixed by the two low bits of the instruction's destination register number. Each bank has its own allocation lane, so as many as four instructions can be entered in one clock when their destinations fall in different banks. An entry index is formed as `{slot, bank}`, so its two low bits always equal the destination's two low bits. Because of this, an entry only needs to keep a 6-bit reduced tag instead of the full register identity.

Within a bank, entries are allocated and freed in order. Across banks, a global sequence number keeps program order, and commit walks that order one entry per clock. The oldest entry commits only after its result has been written back. Operand lookup is an associative search inside a single bank, and it returns the youngest matching entry. A flush empties the whole structure in one cycle.

The total entry count has to exceed the latency of the slowest execution unit, the 32-bit divider, by a few clocks. A run of instructions that all target one bank fills only that bank. That bank then stalls while the others still have free slots. The parameters in `rob_pkg` set the sizes. Depths must be powers of two.

Top module: `banked_rob`

## Requirements
- R1: After reset, all four `alloc_ready` bits are 1, `ret_valid` is 0 and `srch_hit` is 0.
- R2: Lane b accepts only a destination whose bits [1:0] equal b, and a request on a lane that does not match is ignored. `alloc_idx` lane b (bits [5b+4:5b]) shows `{slot[2:0], b[1:0]}`. Within a bank, slots are handed out in the order 0..7 and then wrap.
- R3: A bank holds 8 entries. When its bank is full, `alloc_ready[b]` is 0 and a request on that lane is ignored. The other lanes are unaffected.
- R4: All four lanes can allocate in the same cycle. Lane 0 counts as oldest and lane 3 as youngest.
- R5: Entries commit in global allocation order across the banks, at most one per clock.
- R6: The oldest entry commits only after its done flag is set. Younger entries that are already done wait behind it.
- R7: When `wb_valid` is high, the entry `wb_idx` is marked done. A writeback to an entry that is not valid has no effect.
- R8: A search takes a tag, with bit 5 = floating-point flag and bits [4:0] = register bits [6:2], plus a bank number. It reports a hit on the youngest valid matching entry of that bank, along with that entry's index and done flag.
- R9: A flush empties every bank and resets all pointers, so the next allocation in each bank uses slot 0. Allocation and commit are suppressed in the flush cycle.
- R10: On commit, the block outputs the entry index, the floating-point flag and the full 7-bit destination register number, rebuilt from the tag and the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard all entries |
| alloc_valid | input | 4 | Per-lane allocation request |
| alloc_fp | input | 4 | Per-lane floating-point destination flag |
| alloc_reg | input | 28 | Per-lane 7-bit destination register, lane b at [7b+6:7b] |
| alloc_ready | output | 4 | Lane's bank has a free slot |
| alloc_idx | output | 20 | Per-lane index the request receives, lane b at [5b+4:5b] |
| wb_valid | input | 1 | Writeback strobe |
| wb_idx | input | 5 | Entry being written back |
| srch_tag | input | 6 | Reduced tag to look up |
| srch_bank | input | 2 | Bank to search |
| srch_hit | output | 1 | A valid entry matched |
| srch_idx | output | 5 | Index of youngest match |
| srch_done | output | 1 | Youngest match has its result |
| ret_valid | output | 1 | Oldest entry commits this cycle |
| ret_idx | output | 5 | Index of committing entry |
| ret_fp | output | 1 | Floating-point flag of committing entry |
| ret_reg | output | 7 | Destination register of committing entry |

## Verification
A corrupted bank pointer shows up immediately on `alloc_idx`. The wrong slot is offered in the same cycle the request is presented. A lost or duplicated sequence number appears later, as the commit stream going out of program order or stopping altogether, at the first commit after the faulty allocation. A stale done or valid flag appears either as a commit that arrives too early or as a search that returns the wrong entry or done value in the same cycle. The bench therefore compares every offered index and every commit against a model of order it keeps itself, and it probes the search between steps.

// File: rtl/rob_pkg.sv
// Package: sizes and shared types for the banked reorder buffer.
// Assumes BANK_DEPTH and NUM_BANKS are powers of two.
package rob_pkg;
    parameter int unsigned NUM_BANKS   = 4;
    parameter int unsigned BANK_DEPTH  = 8;
    parameter int unsigned REG_W       = 7;

    localparam int unsigned BANK_W      = $clog2(NUM_BANKS);
    localparam int unsigned SLOT_W      = $clog2(BANK_DEPTH);
    localparam int unsigned IDX_W       = SLOT_W + BANK_W;
    localparam int unsigned TAG_W       = 1 + REG_W - BANK_W;
    localparam int unsigned NUM_ENTRIES = NUM_BANKS * BANK_DEPTH;
    localparam int unsigned SEQ_W       = $clog2(NUM_ENTRIES) + 1;
    localparam int unsigned CNT_W       = SLOT_W + 1;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [SEQ_W-1:0]  seq_t;
    typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/rob_bank.sv
// Module: one bank of entries, used as an in-order circular queue.
// It stores valid, done, reduced tag and global sequence number for each slot.
// Assumes the caller allocates only when not full and pops only a done head.
module rob_bank
    import rob_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  flush,
    input  logic  alloc_en,
    input  tag_t  alloc_tag,
    input  seq_t  alloc_seq,
    output logic  full,
    output slot_t tail_slot,
    input  logic  wb_en,
    input  slot_t wb_slot,
    input  logic  pop,
    output logic  head_valid,
    output logic  head_done,
    output seq_t  head_seq,
    output tag_t  head_tag,
    output slot_t head_slot,
    input  tag_t  srch_tag,
    output logic  srch_hit,
    output slot_t srch_slot,
    output logic  srch_done
);
    logic [BANK_DEPTH-1:0] valid_q;
    logic [BANK_DEPTH-1:0] done_q;
    tag_t                  tag_q [BANK_DEPTH];
    seq_t                  seq_q [BANK_DEPTH];
    slot_t                 head_q;
    slot_t                 tail_q;
    cnt_t                  count_q;

    // Pointer, occupancy and flag state; flush acts like reset.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid_q <= '0;
            done_q  <= '0;
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (wb_en && valid_q[wb_slot]) begin
                done_q[wb_slot] <= 1'b1;
            end
            if (alloc_en) begin
                valid_q[tail_q] <= 1'b1;
                done_q[tail_q]  <= 1'b0;
                tail_q          <= tail_q + slot_t'(1);
            end
            if (pop) begin
                valid_q[head_q] <= 1'b0;
                head_q          <= head_q + slot_t'(1);
            end
            count_q <= count_q + cnt_t'(alloc_en) - cnt_t'(pop);
        end
    end

    // Payload written on allocation; no reset needed, gated by valid.
    always_ff @(posedge clk) begin
        if (alloc_en) begin
            tag_q[tail_q] <= alloc_tag;
            seq_q[tail_q] <= alloc_seq;
        end
    end

    // Status towards allocation and commit.
    always_comb begin
        full       = (count_q == cnt_t'(BANK_DEPTH));
        tail_slot  = tail_q;
        head_slot  = head_q;
        head_valid = valid_q[head_q];
        head_done  = done_q[head_q];
        head_seq   = seq_q[head_q];
        head_tag   = tag_q[head_q];
    end

    // Associative search: walk oldest to youngest so the last match wins.
    always_comb begin
        srch_hit  = 1'b0;
        srch_slot = '0;
        srch_done = 1'b0;
        for (int k = 0; k < BANK_DEPTH; k++) begin
            if (valid_q[slot_t'(head_q + slot_t'(k))] &&
                tag_q[slot_t'(head_q + slot_t'(k))] == srch_tag) begin
                srch_hit  = 1'b1;
                srch_slot = slot_t'(head_q + slot_t'(k));
                srch_done = done_q[slot_t'(head_q + slot_t'(k))];
            end
        end
    end

    // R3: never allocate into a bank that already holds BANK_DEPTH entries.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> (count_q < cnt_t'(BANK_DEPTH)));

    // R6: only a valid, completed head may leave the bank.
    a_r6_pop_done: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (valid_q[head_q] && done_q[head_q]));
endmodule

// File: rtl/rob_seqgen.sv
// Module: hands out global sequence numbers to the lanes accepted this cycle.
// Lane 0 is treated as oldest. The counter advances by the number accepted.
module rob_seqgen
    import rob_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic [NUM_BANKS-1:0] acc,
    output seq_t                 lane_seq [NUM_BANKS],
    output seq_t                 next_seq
);
    seq_t seq_q;
    seq_t run;

    // Prefix count of accepted lanes gives each lane its number.
    always_comb begin
        run = seq_q;
        for (int b = 0; b < NUM_BANKS; b++) begin
            lane_seq[b] = run;
            if (acc[b]) begin
                run = run + seq_t'(1);
            end
        end
    end

    // Allocation sequence register.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            seq_q <= '0;
        end else begin
            seq_q <= run;
        end
    end

    assign next_seq = seq_q;
endmodule

// File: rtl/rob_retire.sv
// Module: commit pointer that walks the global sequence across banks.
// It picks the bank whose head carries the expected sequence number and pops
// that head once it is done. Assumes sequence numbers are dense.
module rob_retire
    import rob_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic [NUM_BANKS-1:0] head_valid,
    input  logic [NUM_BANKS-1:0] head_done,
    input  seq_t                 head_seq [NUM_BANKS],
    output logic [NUM_BANKS-1:0] pop,
    output logic                 fire,
    output bank_t                ret_bank,
    output seq_t                 ret_seq
);
    seq_t                 ret_seq_q;
    logic [NUM_BANKS-1:0] cand;

    // Locate the oldest entry and decide whether it commits.
    always_comb begin
        ret_bank = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            cand[b] = head_valid[b] && (head_seq[b] == ret_seq_q);
            if (cand[b]) begin
                ret_bank = bank_t'(b);
            end
        end
        fire = (|(cand & head_done)) && !flush;
        pop  = fire ? (cand & head_done) : '0;
    end

    // Commit sequence register.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ret_seq_q <= '0;
        end else if (fire) begin
            ret_seq_q <= ret_seq_q + seq_t'(1);
        end
    end

    assign ret_seq = ret_seq_q;

    // R5: at most one bank head can be the globally oldest entry.
    a_r5_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cand));
endmodule

// File: rtl/banked_rob.sv
// Module: top of the register-banked reorder buffer.
// Lane b feeds bank b; index = {slot, bank}; one commit per clock in order.
// Assumes the sizes in rob_pkg; flush has priority over all other inputs.
module banked_rob
    import rob_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic [NUM_BANKS-1:0]       alloc_valid,
    input  logic [NUM_BANKS-1:0]       alloc_fp,
    input  logic [NUM_BANKS*REG_W-1:0] alloc_reg,
    output logic [NUM_BANKS-1:0]       alloc_ready,
    output logic [NUM_BANKS*IDX_W-1:0] alloc_idx,
    input  logic                       wb_valid,
    input  logic [IDX_W-1:0]           wb_idx,
    input  logic [TAG_W-1:0]           srch_tag,
    input  logic [BANK_W-1:0]          srch_bank,
    output logic                       srch_hit,
    output logic [IDX_W-1:0]           srch_idx,
    output logic                       srch_done,
    output logic                       ret_valid,
    output logic [IDX_W-1:0]           ret_idx,
    output logic                       ret_fp,
    output logic [REG_W-1:0]           ret_reg
);
    logic [NUM_BANKS-1:0] full, acc, wb_en, pop;
    logic [NUM_BANKS-1:0] head_valid, head_done;
    logic [NUM_BANKS-1:0] b_hit, b_done;
    slot_t                tail_slot [NUM_BANKS];
    slot_t                head_slot [NUM_BANKS];
    slot_t                b_slot    [NUM_BANKS];
    seq_t                 head_seq  [NUM_BANKS];
    tag_t                 head_tag  [NUM_BANKS];
    seq_t                 lane_seq  [NUM_BANKS];
    seq_t                 next_seq, ret_seq;
    bank_t                ret_bank;
    logic                 fire;
    tag_t                 ret_tag;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [REG_W-1:0] lane_reg;
        tag_t             lane_tag;

        // Lane decode: bank match, acceptance and reduced tag.
        always_comb begin
            lane_reg    = alloc_reg[b*REG_W +: REG_W];
            lane_tag    = {alloc_fp[b], lane_reg[REG_W-1:BANK_W]};
            acc[b]      = alloc_valid[b] && !full[b] && !flush &&
                          (lane_reg[BANK_W-1:0] == bank_t'(b));
            alloc_ready[b] = !full[b];
            alloc_idx[b*IDX_W +: IDX_W] = {tail_slot[b], bank_t'(b)};
            wb_en[b]    = wb_valid && (wb_idx[BANK_W-1:0] == bank_t'(b));
        end

        rob_bank u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (flush),
            .alloc_en   (acc[b]),
            .alloc_tag  (lane_tag),
            .alloc_seq  (lane_seq[b]),
            .full       (full[b]),
            .tail_slot  (tail_slot[b]),
            .wb_en      (wb_en[b]),
            .wb_slot    (wb_idx[IDX_W-1:BANK_W]),
            .pop        (pop[b]),
            .head_valid (head_valid[b]),
            .head_done  (head_done[b]),
            .head_seq   (head_seq[b]),
            .head_tag   (head_tag[b]),
            .head_slot  (head_slot[b]),
            .srch_tag   (srch_tag),
            .srch_hit   (b_hit[b]),
            .srch_slot  (b_slot[b]),
            .srch_done  (b_done[b])
        );
    end

    rob_seqgen u_seqgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .acc      (acc),
        .lane_seq (lane_seq),
        .next_seq (next_seq)
    );

    rob_retire u_retire (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .head_valid (head_valid),
        .head_done  (head_done),
        .head_seq   (head_seq),
        .pop        (pop),
        .fire       (fire),
        .ret_bank   (ret_bank),
        .ret_seq    (ret_seq)
    );

    // Search result: select the addressed bank.
    always_comb begin
        srch_hit  = b_hit[srch_bank];
        srch_done = b_done[srch_bank];
        srch_idx  = {b_slot[srch_bank], srch_bank};
    end

    // Commit output: rebuild full register from reduced tag and bank.
    always_comb begin
        ret_tag   = head_tag[ret_bank];
        ret_valid = fire;
        ret_idx   = {head_slot[ret_bank], ret_bank};
        ret_fp    = ret_tag[TAG_W-1];
        ret_reg   = {ret_tag[TAG_W-2:0], ret_bank};
    end

    // R3: in-flight entries never exceed total capacity.
    a_r3_window: assert property (@(posedge clk) disable iff (!rst_n)
        seq_t'(next_seq - ret_seq) <= seq_t'(NUM_ENTRIES));

    // R9: one cycle after a flush nothing is held or committing.
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (alloc_ready == '1 && !ret_valid && !srch_hit));
endmodule

// File: tb/banked_rob_tb_top.sv
module banked_rob_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [3:0]  alloc_valid = '0;
    logic [3:0]  alloc_fp = '0;
    logic [27:0] alloc_reg = '0;
    logic [3:0]  alloc_ready;
    logic [19:0] alloc_idx;
    logic        wb_valid = 1'b0;
    logic [4:0]  wb_idx = '0;
    logic [5:0]  srch_tag = '0;
    logic [1:0]  srch_bank = '0;
    logic        srch_hit, srch_done, ret_valid, ret_fp;
    logic [4:0]  srch_idx, ret_idx;
    logic [6:0]  ret_reg;

    int n_checks = 0;
    int n_fail = 0;
    int n_ret = 0;
    bit finished = 0;
    logic [12:0] exp_q [$];
    int mtail [4] = '{0, 0, 0, 0};

    always #2 clk = ~clk;

    banked_rob dut_i (.*);

    task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: every commit is popped from the scoreboard and compared (R5, R10).
    always @(negedge clk) begin
        if (rst_n && ret_valid) begin
            n_ret++;
            if (exp_q.size() == 0) begin
                expect_eq("R5 unexpected commit", {19'd0, ret_idx, ret_fp, ret_reg}, 32'h0);
            end else begin
                expect_eq("R5/R10 commit order and content",
                          {19'd0, ret_idx, ret_fp, ret_reg}, {19'd0, exp_q.pop_front()});
            end
        end
    end

    // Driver: present one cycle of requests, check offered indices, push expectations.
    task automatic do_alloc(input logic [3:0] m, input logic [3:0] fpv,
                            input logic [27:0] regs, input logic [3:0] exp_acc);
        @(posedge clk); #1;
        alloc_valid = m; alloc_fp = fpv; alloc_reg = regs;
        @(negedge clk);
        for (int b = 0; b < 4; b++) begin
            if (m[b] && exp_acc[b]) begin
                expect_eq("R2 offered index", {27'd0, alloc_idx[b*5 +: 5]},
                          {27'd0, 3'(mtail[b]), 2'(b)});
                exp_q.push_back({3'(mtail[b]), 2'(b), fpv[b], regs[b*7 +: 7]});
                mtail[b] = (mtail[b] + 1) % 8;
            end
        end
        @(posedge clk); #1;
        alloc_valid = '0;
    endtask

    task automatic do_wb(input logic [4:0] idx);
        @(posedge clk); #1;
        wb_valid = 1'b1; wb_idx = idx;
        @(posedge clk); #1;
        wb_valid = 1'b0;
    endtask

    task automatic probe(input string req, input logic [5:0] tag, input logic [1:0] bank,
                         input logic hit, input logic [4:0] idx, input logic dn);
        @(posedge clk); #1;
        srch_tag = tag; srch_bank = bank;
        @(negedge clk);
        expect_eq(req, {25'd0, srch_hit, srch_idx, srch_done},
                  {25'd0, hit, hit ? idx : srch_idx, hit ? dn : srch_done});
    endtask

    task automatic drain;
        for (int i = 0; i < 60 && exp_q.size() != 0; i++) @(posedge clk);
        expect_eq("R5 all expected commits seen", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        expect_eq("R1 ready after reset", {28'd0, alloc_ready}, 32'hf);
        expect_eq("R1 no commit after reset", {31'd0, ret_valid}, 0);
        expect_eq("R1 search miss after reset", {31'd0, srch_hit}, 0);

        // R4: four lanes in one cycle; lane 0 oldest
        do_alloc(4'b1111, 4'b0101, {7'd31, 7'd6, 7'd13, 7'd8}, 4'b1111);
        // R6: younger entries done, oldest not: nothing commits
        do_wb(5'd3); do_wb(5'd2); do_wb(5'd1);
        @(negedge clk);
        expect_eq("R6 younger done must wait", {31'd0, ret_valid}, 0);
        do_wb(5'd0);
        drain();

        // R3: fill bank 1 with eight entries; two share a tag (R8)
        for (int k = 0; k < 8; k++) begin
            logic [6:0] r;
            r = (k == 2 || k == 5) ? 7'd21 : 7'((k << 2) | 1);
            do_alloc(4'b0010, (k == 2 || k == 5) ? 4'b0010 : 4'b0000, {14'd0, r, 7'd0}, 4'b0010);
        end
        @(negedge clk);
        expect_eq("R3 only bank 1 reports full", {28'd0, alloc_ready}, 32'hd);
        // R3 request to full bank and R2 mismatched lane request both ignored
        do_alloc(4'b0110, 4'b0000, {7'd0, 7'd5, 7'd1, 7'd0}, 4'b0000);
        probe("R2 mismatched lane not allocated", {1'b0, 5'd1}, 2'd2, 1'b0, 5'd0, 1'b0);
        probe("R8 youngest match in bank", {1'b1, 5'd5}, 2'd1, 1'b1, 5'd25, 1'b0);
        do_wb(5'd25);
        probe("R7/R8 match shows done", {1'b1, 5'd5}, 2'd1, 1'b1, 5'd25, 1'b1);
        for (int k = 0; k < 8; k++) do_wb(5'(((1 + k) % 8) * 4 + 1));
        drain();

        // R7: writeback to an empty slot, then allocate it: must stay not done
        do_wb(5'd4);
        do_alloc(4'b0001, 4'b0000, {21'd0, 7'd12}, 4'b0001);
        probe("R7 stale writeback ignored", {1'b0, 5'd3}, 2'd0, 1'b1, 5'd4, 1'b0);
        @(negedge clk);
        expect_eq("R7 no commit of undone entry", {31'd0, ret_valid}, 0);

        // R9: flush with a simultaneous allocation on lane 3
        @(posedge clk); #1;
        flush = 1'b1; alloc_valid = 4'b1000; alloc_reg = {7'd3, 21'd0};
        @(posedge clk); #1;
        flush = 1'b0; alloc_valid = '0;
        exp_q.delete();
        mtail = '{0, 0, 0, 0};
        @(negedge clk);
        expect_eq("R9 ready after flush", {28'd0, alloc_ready}, 32'hf);
        expect_eq("R9 nothing commits after flush", {31'd0, ret_valid}, 0);
        probe("R9 flushed entry gone", {1'b0, 5'd3}, 2'd0, 1'b0, 5'd0, 1'b0);
        probe("R9 flush-cycle allocation ignored", {1'b0, 5'd0}, 2'd3, 1'b0, 5'd0, 1'b0);

        // R5: cross-bank order 3, 0, 1 in separate cycles, completed out of order
        do_alloc(4'b1000, 4'b1000, {7'd7, 21'd0}, 4'b1000);
        do_alloc(4'b0001, 4'b0000, {21'd0, 7'd0}, 4'b0001);
        do_alloc(4'b0010, 4'b0000, {14'd0, 7'd1, 7'd0}, 4'b0010);
        do_wb(5'd1); do_wb(5'd0);
        @(negedge clk);
        expect_eq("R5 oldest bank-3 entry blocks", {31'd0, ret_valid}, 0);
        do_wb(5'd3);
        drain();
        expect_eq("R5 total commits", n_ret, 15);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL R5 watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule